// File: doc/BRIEF.md
# Multiphase Sampled Edge Timestamper

This block timestamps the rising edges of a slow input with a resolution finer than one reference clock period. Outside the block, the input is sampled by a bank of flip-flops. Each flip-flop is clocked by one of `PHASES` copies of the reference clock, and the copies are spaced evenly over one reference period. With 16 phases of a 100 MHz reference the spacing is 625 ps, which gives an effective 1.6 GHz time grid. The sampled vector arrives on `phase_smp`, and bit 0 is the earliest phase. When an edge lands inside a reference period, the flip-flops clocked before the edge read low and those clocked after it read high. The vector is therefore a thermometer code.

A free-running coarse counter supplies the upper part of each timestamp. The number of low samples supplies the fine part in the low `log2(PHASES)` bits. Every new timestamp is subtracted from the one before it, and the difference is the period of the input counted in fine units. The subtraction is taken modulo the timestamp width, so a rollover of the coarse counter does not corrupt the period. A pattern that breaks the thermometer shape (a bubble) is still decoded by counting its ones, and a flag reports it.

Top module: `tsx_edge_stamper`

## Requirements
- R1: While `rst` is high at a clock edge, `ts_out`, `period_out`, `valid_out` and `bubble_out` are all zero after that edge.
- R2: A capture happens only at a clock edge where `sig_in` is high and was low at the previous edge. If `sig_in` stays high or falls, `ts_out` does not change and `valid_out` stays low.
- R3: The low `log2(PHASES)` bits of a captured timestamp equal `(PHASES - ones) mod PHASES`, where `ones` is the number of high bits in `phase_smp`. An all-high vector therefore gives 0, and a vector with only bit `PHASES-1` high gives `PHASES-1`.
- R4: The upper `COARSE_W` bits of a captured timestamp equal the number of clock edges with `rst` low that came before the capturing edge, modulo 2^COARSE_W.
- R5: The first capture after reset updates `ts_out` but leaves `valid_out` low.
- R6: Every later capture raises `valid_out` for exactly one cycle. In that cycle `period_out` equals the new timestamp minus the previous one, modulo 2^TS_W.
- R7: When the coarse counter wraps between two captures, `period_out` is still the true elapsed time in fine units.
- R8: On each capture, `bubble_out` is set exactly when some bit i of `phase_smp` is high and bit i+1 is low. It holds that value until the next capture. The fine code is still formed from the count of ones.
- R9: While no capture happens, the value of `phase_smp` has no effect on `ts_out`, `period_out` or `bubble_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Input signal sampled on the reference clock |
| phase_smp | input | PHASES | Multiphase sample vector, bit 0 earliest |
| ts_out | output | COARSE_W+log2(PHASES) | Most recent timestamp |
| period_out | output | COARSE_W+log2(PHASES) | Difference between the last two timestamps |
| valid_out | output | 1 | One-cycle strobe for a new period |
| bubble_out | output | 1 | Last captured vector was not a clean thermometer |

## Verification
The bench sweeps clean thermometer vectors over every count of ones from 0 to 16. This separates a correct ones-count decode from an inverted or off-by-one one, and it confirms the wrap of the all-low case to zero. Vectors with bubbles, each holding the same number of ones as a clean vector, separate counting from first-transition search and exercise the flag. The bench also varies the gaps between edges, holds `sig_in` high for more than one cycle, and applies junk vectors between edges. These runs tell a true rising-edge capture apart from level capture and show that `phase_smp` leaks into no output. The run is long enough for the small coarse counter to wrap several times, and a mid-run reset re-tests the first-capture rule.

// File: rtl/tsx_pkg.sv
package tsx_pkg;

    localparam int DEF_PHASES   = 16;
    localparam int DEF_COARSE_W = 28;

    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_FIRST = 2'd1,
        CAP_NEXT  = 2'd2
    } cap_kind_e;

    function automatic cap_kind_e classify_capture(input logic cap, input logic have_prev);
        if (!cap)
            return CAP_IDLE;
        else if (!have_prev)
            return CAP_FIRST;
        else
            return CAP_NEXT;
    endfunction

endpackage

// File: rtl/tsx_therm_decode.sv
module tsx_therm_decode #(
    parameter int PHASES = 16,
    parameter int FINE_W = $clog2(PHASES),
    parameter int CNT_W  = $clog2(PHASES + 1)
) (
    input  logic [PHASES-1:0] smp,
    output logic [FINE_W-1:0] fine,
    output logic [CNT_W-1:0]  ones,
    output logic              bubble
);

    logic [PHASES-2:0] brk;
    logic [CNT_W-1:0]  remain;

    genvar gi;
    generate
        for (gi = 0; gi < PHASES - 1; gi++) begin : g_brk
            assign brk[gi] = smp[gi] & ~smp[gi+1];
        end
    endgenerate

    always_comb begin
        ones = '0;
        for (int i = 0; i < PHASES; i++)
            ones = ones + CNT_W'(smp[i]);
    end

    assign bubble = |brk;
    assign remain = CNT_W'(PHASES) - ones;
    assign fine   = remain[FINE_W-1:0];

    always_comb begin
        // R3
        if (smp == '1) begin
            fine_full_chk: assert (fine == '0);
        end
        // R8
        if (bubble) begin
            bubble_mixed_chk: assert (ones != '0 && ones != CNT_W'(PHASES));
        end
    end

endmodule

// File: rtl/tsx_coarse_cnt.sv
module tsx_coarse_cnt #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> cnt == W'($past(cnt) + 1'b1));

endmodule

// File: rtl/tsx_period_calc.sv
module tsx_period_calc
    import tsx_pkg::*;
#(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cap,
    input  logic [TS_W-1:0] ts_new,
    output logic [TS_W-1:0] ts_q,
    output logic [TS_W-1:0] period_q,
    output logic            valid_q
);

    logic      have_prev;
    cap_kind_e kind;

    assign kind = classify_capture(cap, have_prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_q      <= '0;
            period_q  <= '0;
            valid_q   <= 1'b0;
            have_prev <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            case (kind)
                CAP_FIRST: begin
                    ts_q      <= ts_new;
                    have_prev <= 1'b1;
                end
                CAP_NEXT: begin
                    ts_q     <= ts_new;
                    period_q <= ts_new - ts_q;
                    valid_q  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R5
    first_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == CAP_FIRST) |=> !valid_q);

    // R6
    period_diff_chk: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> period_q == TS_W'(ts_q - $past(ts_q)));

endmodule

// File: rtl/tsx_edge_stamper.sv
module tsx_edge_stamper
    import tsx_pkg::*;
#(
    parameter int PHASES   = DEF_PHASES,
    parameter int COARSE_W = DEF_COARSE_W,
    localparam int FINE_W  = $clog2(PHASES),
    localparam int CNT_W   = $clog2(PHASES + 1),
    localparam int TS_W    = COARSE_W + FINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sig_in,
    input  logic [PHASES-1:0] phase_smp,
    output logic [TS_W-1:0]   ts_out,
    output logic [TS_W-1:0]   period_out,
    output logic              valid_out,
    output logic              bubble_out
);

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
    } stamp_t;

    logic                sig_q;
    logic                cap;
    logic [COARSE_W-1:0] coarse_cnt;
    logic [FINE_W-1:0]   fine_code;
    logic [CNT_W-1:0]    ones_cnt;
    logic                bub_c;
    stamp_t              stamp;

    always_ff @(posedge clk) begin
        if (rst)
            sig_q <= 1'b0;
        else
            sig_q <= sig_in;
    end

    assign cap = sig_in & ~sig_q;

    tsx_coarse_cnt #(.W(COARSE_W)) u_coarse (
        .clk (clk),
        .rst (rst),
        .cnt (coarse_cnt)
    );

    tsx_therm_decode #(.PHASES(PHASES), .FINE_W(FINE_W), .CNT_W(CNT_W)) u_decode (
        .smp    (phase_smp),
        .fine   (fine_code),
        .ones   (ones_cnt),
        .bubble (bub_c)
    );

    assign stamp.coarse = coarse_cnt;
    assign stamp.fine   = fine_code;

    tsx_period_calc #(.TS_W(TS_W)) u_period (
        .clk      (clk),
        .rst      (rst),
        .cap      (cap),
        .ts_new   (stamp),
        .ts_q     (ts_out),
        .period_q (period_out),
        .valid_q  (valid_out)
    );

    always_ff @(posedge clk) begin
        if (rst)
            bubble_out <= 1'b0;
        else if (cap)
            bubble_out <= bub_c;
    end

    // R2
    no_edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(sig_in && !sig_q) |=> ($stable(ts_out) && !valid_out));

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        valid_out |=> !valid_out);

    // R8
    bubble_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (cap && ones_cnt == CNT_W'(PHASES)) |=> !bubble_out);

endmodule

// File: tb/tb_tsx_edge_stamper.sv
module tb_tsx_edge_stamper;

    localparam int P    = 16;
    localparam int CW   = 6;
    localparam int FW   = 4;
    localparam int TSW  = CW + FW;
    localparam int MASK = (1 << TSW) - 1;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           sig_in = 1'b0;
    logic [P-1:0]   phase_smp = '0;
    logic [TSW-1:0] ts_out;
    logic [TSW-1:0] period_out;
    logic           valid_out;
    logic           bubble_out;

    int  n_chk = 0;
    int  n_bad = 0;
    int  cyc = 0;
    int  prev_ts = 0;
    bit  have_prev = 0;
    bit  done = 0;
    int  wraps = 0;

    always #5 clk = ~clk;

    tsx_edge_stamper #(.PHASES(P), .COARSE_W(CW)) dut (
        .clk        (clk),
        .rst        (rst),
        .sig_in     (sig_in),
        .phase_smp  (phase_smp),
        .ts_out     (ts_out),
        .period_out (period_out),
        .valid_out  (valid_out),
        .bubble_out (bubble_out)
    );

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit has_bubble(input logic [P-1:0] s);
        for (int i = 0; i < P - 1; i++)
            if (s[i] && !s[i+1]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [P-1:0] therm(input int m);
        logic [P-1:0] v;
        v = '0;
        for (int i = 0; i < P; i++)
            if (i >= P - m) v[i] = 1'b1;
        return v;
    endfunction

    task automatic check_reset();
        check(ts_out == '0,     "R1", "ts_out",     int'(ts_out), 0);
        check(period_out == '0, "R1", "period_out", int'(period_out), 0);
        check(valid_out == 1'b0,"R1", "valid_out",  int'(valid_out), 0);
        check(bubble_out == 1'b0,"R1","bubble_out", int'(bubble_out), 0);
    endtask

    task automatic do_edge(input logic [P-1:0] s, input int hold, input int gap);
        int  fine_e, coarse_e, exp_ts, exp_per;
        bit  exp_b;
        fine_e   = (P - $countones(s)) % P;
        coarse_e = cyc & ((1 << CW) - 1);
        exp_ts   = ((coarse_e << FW) | fine_e) & MASK;
        exp_b    = has_bubble(s);
        sig_in    = 1'b1;
        phase_smp = s;
        @(negedge clk);
        check(int'(ts_out[FW-1:0]) == fine_e, "R3", "fine code", int'(ts_out[FW-1:0]), fine_e);
        check(int'(ts_out[TSW-1:FW]) == coarse_e, "R4", "coarse part", int'(ts_out[TSW-1:FW]), coarse_e);
        if (!have_prev) begin
            check(valid_out == 1'b0, "R5", "valid on first capture", int'(valid_out), 0);
        end else begin
            exp_per = (exp_ts - prev_ts) & MASK;
            check(valid_out == 1'b1, "R6", "valid strobe", int'(valid_out), 1);
            check(int'(period_out) == exp_per, "R6", "period", int'(period_out), exp_per);
            if (exp_ts < prev_ts) begin
                wraps++;
                check(int'(period_out) == exp_per, "R7", "period across wrap", int'(period_out), exp_per);
            end
        end
        check(bubble_out == exp_b, "R8", "bubble flag", int'(bubble_out), int'(exp_b));
        prev_ts   = exp_ts;
        have_prev = 1'b1;
        for (int h = 0; h < hold; h++) begin
            phase_smp = ~s ^ P'(h * 16'h1357);
            @(negedge clk);
            check(int'(ts_out) == exp_ts, "R2", "ts while held high", int'(ts_out), exp_ts);
            check(valid_out == 1'b0, "R2", "valid while held high", int'(valid_out), 0);
        end
        sig_in = 1'b0;
        for (int g = 0; g < gap; g++) begin
            phase_smp = P'($urandom);
            @(negedge clk);
            check(int'(ts_out) == exp_ts, "R9", "ts between edges", int'(ts_out), exp_ts);
            check(valid_out == 1'b0, "R9", "valid between edges", int'(valid_out), 0);
            check(bubble_out == exp_b, "R9", "bubble between edges", int'(bubble_out), int'(exp_b));
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset();
        rst = 1'b0;

        for (int pass = 0; pass < 3; pass++) begin
            for (int m = 0; m <= P; m++)
                do_edge(therm(m), (m + pass) % 2, 1 + (m + pass) % 3);
        end

        do_edge(16'b1111_1111_0000_0100, 0, 2);
        do_edge(16'b1111_0000_1111_0000, 1, 1);
        do_edge(16'b0101_0101_0101_0101, 0, 3);
        do_edge(16'b1111_1111_1111_1110, 0, 1);
        do_edge(16'b0111_1111_1111_1111, 2, 2);
        do_edge(therm(5), 0, 1);

        check(wraps > 0, "R7", "coarse wrap seen", wraps, 1);

        rst = 1'b1;
        phase_smp = '1;
        sig_in = 1'b1;
        repeat (2) @(negedge clk);
        check_reset();
        sig_in = 1'b0;
        rst = 1'b0;
        have_prev = 1'b0;
        @(negedge clk);
        do_edge(therm(12), 0, 2);
        do_edge(therm(3), 0, 1);

        done = 1'b1;
        finish_up();
    end

endmodule